// File: doc/BRIEF.md
# Cycle-Stealing Video Memory Fetch Sequencer

This block lets a display controller borrow a host processor's bus to read screen memory. When a timing event arrives it raises an active-high processor-disable line. It then waits a fixed number of timing units before it turns on its address drivers. After a further fixed count it issues active-low read strobes. Each byte it reads goes into a line buffer at a column index. Once the burst is complete the block floats its address drivers. After a final fixed margin it lowers the disable line and the processor runs again. One timing unit is 250 ns, which is `CLKS_PER_UNIT` clocks.

Screen memory is two halves of 256 bytes each, so text mode holds 512 characters. A frame event starts a prefetch burst during the blank lines. This burst reads the first 16 bytes of each half. A line event starts a display burst. It reads `LINE_BYTES` bytes from each half, starting at a line pointer. The frame event sets the pointer to 16, so the first display burst reads the 17th and 18th bytes of each half. Each display burst then advances the pointer. The margins depend on the kind of burst: prefetch, first display line, text line or graphics line. The release margin also depends on whether the burst is the last one of the region.

Top module: `vid_bus_steal`

## Requirements
- R1: After a synchronous reset, `cpu_dis` is 0, `addr_oe` is 0, `rd_n` is 1, `lb_we` is 0 and `bus_clash` is 0.
- R2: In a burst started by `frame_start`, `addr_oe` rises 15 units after `cpu_dis` rises. The first `rd_n` low comes 25 units after `cpu_dis` rises. `cpu_dis` falls 21 units after `addr_oe` falls.
- R3: A prefetch burst reads offsets 0..15 of half 0 and then offsets 0..15 of half 1. The address is {half, offset}, with the half in bit 8. The line-buffer index is half*16 + offset.
- R4: The first `line_start` burst after a frame burst drives the address 21 units after `cpu_dis` rises. Its first strobe comes 30 units after `cpu_dis` rises.
- R5: A later line burst in text mode (`gfx_mode`=0) drives at 14 units and strobes first at 34 units. If `last_line` is 0, it releases 9 units after the float.
- R6: A later line burst in graphics mode (`gfx_mode`=1) drives at 18 units and strobes first at 38 units. If `last_line` is 0, it releases 13 units after the float.
- R7: A line burst with `last_line`=1 releases 13 units after the float, in either mode.
- R8: Each strobe stays low for 2 units. Strobes within a burst are separated by 1 unit high. The address is steady while a strobe is low. `rd_data` is captured as the strobe rises, with `lb_we` high for one clock.
- R9: A line burst reads `LINE_BYTES` offsets from each half, half 0 first, starting at the line pointer. The buffer index is half*`LINE_BYTES` + k. The pointer becomes 16 on `frame_start` and advances by `LINE_BYTES` after each line burst.
- R10: `frame_start` or `line_start` is ignored while a burst is in progress. When both arrive together while the block is idle, `frame_start` wins.
- R11: `addr_oe` is high only while `cpu_dis` is high. `cpu_dis` never falls while `addr_oe` is high. `bus_clash` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-clock pulse that starts the blank-line prefetch |
| line_start | input | 1 | One-clock pulse that starts a display-line burst |
| last_line | input | 1 | Sampled with `line_start`: this burst is the last of the region |
| gfx_mode | input | 1 | Sampled with `line_start`: 0 text, 1 graphics |
| rd_data | input | 8 | Read data bus |
| cpu_dis | output | 1 | Processor disable, active high |
| addr | output | 9 | Screen memory address {half, offset} |
| addr_oe | output | 1 | Address driver enable |
| rd_n | output | 1 | Read strobe, active low |
| lb_we | output | 1 | Line-buffer write enable |
| lb_idx | output | 5 | Line-buffer column index |
| lb_data | output | 8 | Line-buffer write data |
| bus_clash | output | 1 | High if the address is driven while the processor is enabled |

## Verification
The block samples an event at a clock edge and raises `cpu_dis` after that same edge. From then on, each margin of N units changes its output exactly N*`CLKS_PER_UNIT` clocks later. The bench drives inputs on falling edges and counts the falling edges spent in each interval: disable to drive, disable to first strobe, strobe low, strobe gap, and float to release. It compares each count with the unit count the requirement gives. Each line-buffer write appears together with the rising strobe, so the bench checks its index and data on the first falling edge after that rise.

// File: rtl/vbs_pkg.sv
// Package vbs_pkg: shared state type, margin record and the unit counts
// of every bus-steal phase. All counts are in sequencer timing units.
package vbs_pkg;
    localparam int MW = 6;

    localparam int unsigned PRE_DRV  = 15;
    localparam int unsigned PRE_RD   = 25;
    localparam int unsigned PRE_REL  = 21;
    localparam int unsigned MAIN_DRV = 21;
    localparam int unsigned MAIN_RD  = 30;
    localparam int unsigned TXT_DRV  = 14;
    localparam int unsigned TXT_RD   = 34;
    localparam int unsigned TXT_REL  = 9;
    localparam int unsigned GFX_DRV  = 18;
    localparam int unsigned GFX_RD   = 38;
    localparam int unsigned GFX_REL  = 13;
    localparam int unsigned END_REL  = 13;
    localparam int unsigned STB_LO   = 2;
    localparam int unsigned STB_GAP  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_DRIVE,
        ST_RD_LO,
        ST_RD_HI,
        ST_RELEASE
    } seq_st_t;

    typedef struct packed {
        logic [MW-1:0] drv;
        logic [MW-1:0] rd;
        logic [MW-1:0] rel;
    } margin_t;
endpackage

// File: rtl/vbs_unit_timer.sv
// vbs_unit_timer: a prescaler that makes one tick per timing unit, and a
// unit counter. Both clear on restart. The due output fires in the last
// clock of unit number target, so a state change made on due appears
// exactly target units after the restart.
// Assumes target >= 1 whenever due is used.
module vbs_unit_timer #(
    parameter int CLKS_PER_UNIT = 25,
    parameter int MW            = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [MW-1:0] target,
    output logic          due
);
    localparam int PW = (CLKS_PER_UNIT > 1) ? $clog2(CLKS_PER_UNIT) : 1;

    logic          tick;
    logic [MW-1:0] ucnt;

    generate
        if (CLKS_PER_UNIT > 1) begin : g_presc
            logic [PW-1:0] pcnt;
            assign tick = (pcnt == PW'(CLKS_PER_UNIT - 1));
            // Count clocks within one unit.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) pcnt <= '0;
                else if (tick)         pcnt <= '0;
                else                   pcnt <= pcnt + PW'(1);
            end
        end else begin : g_nopresc
            assign tick = 1'b1;
        end
    endgenerate

    // Count whole units since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) ucnt <= '0;
        else if (tick)         ucnt <= ucnt + MW'(1);
    end

    assign due = tick && (ucnt == target - MW'(1));
endmodule

// File: rtl/vbs_margin_sel.sv
// vbs_margin_sel: chooses the drive, first-read and release margins for the
// current burst. The choice depends on the burst kind, the mode, whether this
// is the first display line and whether it is the last.
// Assumes its inputs are the flags latched when the burst started.
module vbs_margin_sel
    import vbs_pkg::*;
(
    input  logic    pre,
    input  logic    gfx,
    input  logic    first,
    input  logic    last,
    output margin_t m
);
    // Look up the margins for this burst.
    always_comb begin
        if (pre) begin
            m.drv = MW'(PRE_DRV);
            m.rd  = MW'(PRE_RD);
            m.rel = MW'(PRE_REL);
        end else begin
            if (first) begin
                m.drv = MW'(MAIN_DRV);
                m.rd  = MW'(MAIN_RD);
            end else if (gfx) begin
                m.drv = MW'(GFX_DRV);
                m.rd  = MW'(GFX_RD);
            end else begin
                m.drv = MW'(TXT_DRV);
                m.rd  = MW'(TXT_RD);
            end
            if (last)     m.rel = MW'(END_REL);
            else if (gfx) m.rel = MW'(GFX_REL);
            else          m.rel = MW'(TXT_REL);
        end
    end
endmodule

// File: rtl/vbs_fetch_addr.sv
// vbs_fetch_addr: walks through the bytes of one burst, half 0 first and then
// half 1. It produces the screen address, the line-buffer column and a flag
// for the final byte. It also keeps the line pointer, which a prefetch sets
// and each line burst advances.
// Assumes the byte counts fit within half of the index range.
module vbs_fetch_addr #(
    parameter int HALF_BITS  = 8,
    parameter int PRE_BYTES  = 16,
    parameter int LINE_BYTES = 2,
    parameter int IW         = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_pre,
    input  logic               step,
    input  logic               done,
    output logic [HALF_BITS:0] addr,
    output logic [IW-1:0]      idx,
    output logic               last_byte
);
    localparam int KW = IW - 1;

    logic                 pre_q;
    logic                 half_q;
    logic [KW-1:0]        k_q;
    logic [HALF_BITS-1:0] ptr_q;
    logic [IW-1:0]        n_w;
    logic [IW-1:0]        k_w;
    logic                 row_end;
    logic [HALF_BITS-1:0] base;

    assign n_w       = pre_q ? IW'(PRE_BYTES) : IW'(LINE_BYTES);
    assign k_w       = {1'b0, k_q};
    assign row_end   = (k_w == n_w - IW'(1));
    assign last_byte = half_q && row_end;
    assign base      = pre_q ? '0 : ptr_q;
    assign addr      = {half_q, base + HALF_BITS'(k_q)};
    assign idx       = half_q ? (n_w + k_w) : k_w;

    // Move to the next byte of the burst, or restart the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= 1'b1;
            half_q <= 1'b0;
            k_q    <= '0;
        end else if (start) begin
            pre_q  <= start_pre;
            half_q <= 1'b0;
            k_q    <= '0;
        end else if (step) begin
            if (row_end) begin
                k_q    <= '0;
                half_q <= 1'b1;
            end else begin
                k_q <= k_q + KW'(1);
            end
        end
    end

    // Keep the line pointer: a prefetch sets it, each line burst advances it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ptr_q <= HALF_BITS'(PRE_BYTES);
        else if (start && start_pre) ptr_q <= HALF_BITS'(PRE_BYTES);
        else if (done && !pre_q)     ptr_q <= ptr_q + HALF_BITS'(LINE_BYTES);
    end

    // R3: no step takes the column past the byte count of the burst.
    a_r3_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (k_w < n_w));
endmodule

// File: rtl/vid_bus_steal.sv
// vid_bus_steal: takes the processor bus away to fetch screen bytes. It raises
// the disable line, drives the address after a margin, strobes each byte, then
// floats the address and releases the bus after another margin.
// Assumes frame_start and line_start are one-clock pulses from the display
// timing, and that read data is valid while the strobe is low.
module vid_bus_steal
    import vbs_pkg::*;
#(
    parameter int CLKS_PER_UNIT = 25,
    parameter int HALF_BITS     = 8,
    parameter int PRE_BYTES     = 16,
    parameter int LINE_BYTES    = 2,
    parameter int DW            = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                line_start,
    input  logic                last_line,
    input  logic                gfx_mode,
    input  logic [DW-1:0]       rd_data,
    output logic                cpu_dis,
    output logic [HALF_BITS:0]  addr,
    output logic                addr_oe,
    output logic                rd_n,
    output logic                lb_we,
    output logic [$clog2(2*((PRE_BYTES > LINE_BYTES) ? PRE_BYTES : LINE_BYTES))-1:0] lb_idx,
    output logic [DW-1:0]       lb_data,
    output logic                bus_clash
);
    localparam int MAXB = (PRE_BYTES > LINE_BYTES) ? PRE_BYTES : LINE_BYTES;
    localparam int IW   = $clog2(2 * MAXB);

    seq_st_t       st, nxt;
    logic          restart, start, step, done, cap, due, last_byte;
    logic [MW-1:0] target;
    logic          pre_q, gfx_q, first_q, last_q;
    margin_t       m;
    logic [IW-1:0] idx;

    vbs_unit_timer #(.CLKS_PER_UNIT(CLKS_PER_UNIT), .MW(MW)) timer_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .target(target), .due(due)
    );

    vbs_margin_sel msel_i (
        .pre(pre_q), .gfx(gfx_q), .first(first_q), .last(last_q), .m(m)
    );

    vbs_fetch_addr #(.HALF_BITS(HALF_BITS), .PRE_BYTES(PRE_BYTES),
                     .LINE_BYTES(LINE_BYTES), .IW(IW)) fetch_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_pre(frame_start),
        .step(step), .done(done), .addr(addr), .idx(idx), .last_byte(last_byte)
    );

    // Choose the next phase and the margin the timer counts toward.
    always_comb begin
        nxt     = st;
        restart = 1'b0;
        start   = 1'b0;
        step    = 1'b0;
        done    = 1'b0;
        cap     = 1'b0;
        target  = MW'(1);
        case (st)
            ST_IDLE: begin
                if (frame_start || line_start) begin
                    nxt     = ST_HOLD;
                    restart = 1'b1;
                    start   = 1'b1;
                end
            end
            ST_HOLD: begin
                target = m.drv;
                if (due) nxt = ST_DRIVE;
            end
            ST_DRIVE: begin
                target = m.rd;
                if (due) begin
                    nxt     = ST_RD_LO;
                    restart = 1'b1;
                end
            end
            ST_RD_LO: begin
                target = MW'(STB_LO);
                if (due) begin
                    cap     = 1'b1;
                    step    = 1'b1;
                    restart = 1'b1;
                    nxt     = last_byte ? ST_RELEASE : ST_RD_HI;
                end
            end
            ST_RD_HI: begin
                target = MW'(STB_GAP);
                if (due) begin
                    nxt     = ST_RD_LO;
                    restart = 1'b1;
                end
            end
            ST_RELEASE: begin
                target = m.rel;
                if (due) begin
                    nxt  = ST_IDLE;
                    done = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Latch the kind, mode and region flags when a burst starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= 1'b0;
            gfx_q   <= 1'b0;
            first_q <= 1'b0;
            last_q  <= 1'b0;
        end else if (start) begin
            pre_q  <= frame_start;
            gfx_q  <= gfx_mode;
            last_q <= last_line;
            if (frame_start) first_q <= 1'b1;
        end else if (done && !pre_q) begin
            first_q <= 1'b0;
        end
    end

    // Capture read data into the line buffer as the strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lb_we   <= 1'b0;
            lb_idx  <= '0;
            lb_data <= '0;
        end else begin
            lb_we <= cap;
            if (cap) begin
                lb_idx  <= idx;
                lb_data <= rd_data;
            end
        end
    end

    assign cpu_dis   = (st != ST_IDLE);
    assign addr_oe   = (st == ST_DRIVE) || (st == ST_RD_LO) || (st == ST_RD_HI);
    assign rd_n      = (st != ST_RD_LO);
    assign bus_clash = addr_oe && !cpu_dis;

    // R11: the address is driven only while the processor is held off.
    a_r11_oe_needs_dis: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |-> cpu_dis);
    // R11: the drivers turn on only after disable was already high.
    a_r11_drive_after_dis: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe) |-> $past(cpu_dis));
    // R11: disable falls only after the drivers were already off.
    a_r11_drop_after_float: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_dis) |-> !$past(addr_oe));
    // R11: the clash flag never rises.
    a_r11_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_clash);
    // R8: a strobe appears only while the address is driven.
    a_r8_strobe_in_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> addr_oe);
    // R8: the address does not move while a strobe is low.
    a_r8_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && $past(!rd_n)) |-> $stable(addr));
    // R8: each buffer write coincides with a strobe rising.
    a_r8_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        lb_we |-> $rose(rd_n));
endmodule

// File: tb/vid_bus_steal_tb_top.sv
// Self-checking bench for vid_bus_steal. It measures every margin in clocks,
// checks each line-buffer write against a memory model, and covers event
// priority and events that arrive while a burst is running.
module vid_bus_steal_tb_top;
    localparam int U  = 2;
    localparam int LB = 2;
    localparam int PB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0, line_start = 1'b0;
    logic       last_line = 1'b0, gfx_mode = 1'b0;
    logic [7:0] rd_data;
    logic       cpu_dis, addr_oe, rd_n, lb_we, bus_clash;
    logic [8:0] addr;
    logic [4:0] lb_idx;
    logic [7:0] lb_data;

    int checks = 0;
    int errors = 0;
    int clash_seen = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [8:0] a);
        return a[7:0] ^ {a[8], 7'h35};
    endfunction

    assign rd_data = addr_oe ? mem_byte(addr) : 8'h00;

    vid_bus_steal #(.CLKS_PER_UNIT(U), .LINE_BYTES(LB), .PRE_BYTES(PB)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_start(line_start), .last_line(last_line), .gfx_mode(gfx_mode),
        .rd_data(rd_data), .cpu_dis(cpu_dis), .addr(addr), .addr_oe(addr_oe),
        .rd_n(rd_n), .lb_we(lb_we), .lb_idx(lb_idx), .lb_data(lb_data),
        .bus_clash(bus_clash)
    );

    // R11 monitor: count any driven address while the processor is enabled.
    always @(negedge clk) begin
        if (rst_n && ((addr_oe && !cpu_dis) || bus_clash)) clash_seen++;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Start one burst and measure it. The poke option raises both events in
    // the middle of the burst.
    task automatic burst(input bit fs, input bit ls, input bit g, input bit lst,
                         input int drv, input int rd, input int rel,
                         input int base, input int n, input string req,
                         input string dreq, input bit poke);
        int c_drv = 0, c_rd = 0, c_rel = 0, nw = 0, bad = 0;
        int lo = 0, badlo = 0, gap = 0, it = 0;
        bit seen_oe = 0, seen_rd = 0, poked = 0;
        int half, k;
        logic [8:0] a;
        @(negedge clk);
        frame_start = fs; line_start = ls; gfx_mode = g; last_line = lst;
        @(negedge clk);
        frame_start = 1'b0; line_start = 1'b0;
        while (it < 20000) begin
            it++;
            if (!cpu_dis) break;
            if (!addr_oe && !seen_oe) c_drv++;
            if (addr_oe) seen_oe = 1;
            if (rd_n && !seen_rd) c_rd++;
            if (!rd_n) begin
                seen_rd = 1;
                lo++;
            end else if (lo != 0) begin
                if (lo != 2 * U) badlo++;
                lo = 0;
            end
            if (seen_rd && addr_oe && rd_n) gap++;
            if (seen_oe && !addr_oe) c_rel++;
            if (lb_we) begin
                half = nw / n;
                k    = nw % n;
                a    = {half[0], 8'((base + k) % 256)};
                if (int'(lb_idx) != nw || lb_data != mem_byte(a)) bad++;
                nw++;
            end
            if (poke && nw == 1 && !poked) begin
                frame_start = 1'b1; line_start = 1'b1; poked = 1;
            end else begin
                frame_start = 1'b0; line_start = 1'b0;
            end
            @(negedge clk);
        end
        frame_start = 1'b0; line_start = 1'b0;
        check(req, "disable to address drive", c_drv, drv * U);
        check(req, "disable to first strobe", c_rd, rd * U);
        check(req, "float to release", c_rel, rel * U);
        check(dreq, "bytes written", nw, 2 * n);
        check(dreq, "mismatched writes", bad, 0);
        check("R8", "strobes of wrong length", badlo, 0);
        check("R8", "strobe gap clocks", gap, (2 * n - 1) * U);
    endtask

    typedef struct packed {
        bit gfx;
        bit last;
        int drv;
        int rd;
        int rel;
        int base;
        int tag;
    } vec_t;

    // Lines of one region: R4 first line, R5 text, R6 graphics, R7 last line.
    localparam vec_t VECS [5] = '{
        '{1'b0, 1'b0, 21, 30,  9, 16, 4},
        '{1'b0, 1'b0, 14, 34,  9, 18, 5},
        '{1'b1, 1'b0, 18, 38, 13, 20, 6},
        '{1'b1, 1'b1, 18, 38, 13, 22, 7},
        '{1'b0, 1'b1, 14, 34, 13, 24, 7}
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int idle_hi;
        repeat (4) @(negedge clk);
        // R1: outputs after reset.
        check("R1", "cpu_dis", int'(cpu_dis), 0);
        check("R1", "addr_oe", int'(addr_oe), 0);
        check("R1", "rd_n", int'(rd_n), 1);
        check("R1", "lb_we", int'(lb_we), 0);
        check("R1", "bus_clash", int'(bus_clash), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 margins and R3 byte order for the blank-line prefetch.
        burst(1, 0, 0, 0, 15, 25, 21, 0, PB, "R2", "R3", 0);

        // Vector table: display lines, R9 pointer walk.
        for (int i = 0; i < 5; i++) begin
            burst(0, 1, VECS[i].gfx, VECS[i].last, VECS[i].drv, VECS[i].rd,
                  VECS[i].rel, VECS[i].base, LB,
                  $sformatf("R%0d", VECS[i].tag), "R9", 0);
        end

        // R10: both events together start a prefetch; events mid-burst ignored.
        burst(1, 1, 0, 0, 15, 25, 21, 0, PB, "R10", "R10", 1);
        idle_hi = 0;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            if (cpu_dis) idle_hi++;
        end
        check("R10", "bursts started by ignored events", idle_hi, 0);

        // R9 pointer reset and R4 first-line margins in graphics mode.
        burst(0, 1, 1, 0, 21, 30, 13, 16, LB, "R4", "R9", 0);

        check("R11", "clash cycles", clash_seen, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule